// File: doc/BRIEF.md
# Double-Buffered Peripheral DMA Channel

This block is a single DMA channel that moves bytes between a byte-wide memory request port and a peripheral byte stream. The stream can run in either direction. A CPU register interface holds two buffer descriptor slots, each made of a byte count and a base address. Software arms these slots in ping-pong order, so the next buffer can be queued while the current one is still moving.

A four-state activity machine tracks how many buffers are armed: idle, stall, on and next. Software reads that state from a status field. The channel raises a stall condition when no buffer remains and a next-free-buffer condition when one slot is free for refilling. A peripheral error input sets a sticky error flag. A single interrupt line combines the conditions that are enabled.

When software clears the channel enable, the buffer in flight runs to its end. The channel then passes through stall to idle, and software can poll the state to confirm the drain.

Top module: `dma_chan`

## Requirements
- R1: After reset every register reads zero, the state is idle (0), `irq` is low and `mem_req` is low.
- R2: Register offsets are: control 0x00, interrupt status 0x04, port select 0x08, status 0x0C, bytes remaining 0x14, slot 0 count/base 0x20/0x24, slot 1 count/base 0x30/0x34. The control bits are: stall interrupt enable bit 0, next-free interrupt enable bit 1, direction bit 2 (1 = peripheral to memory), error interrupt enable bit 3, channel enable bit 4. `reg_rdata` shows the addressed register one cycle after `reg_addr`, and the port select register drives `port_sel`.
- R3: Setting the enable moves the state from idle to stall. Status bits [5:4] hold the state and bit 0 holds the active slot. A base write while disabled arms nothing.
- R4: A base write to a free slot arms it. In stall this moves the state to on (2) with that slot active. In on, arming the other slot moves the state to next (3).
- R5: In memory-to-peripheral mode, bytes read from addresses base..base+count-1 appear on `tx_data` in address order. Each byte is held stable while `tx_valid` is high and `tx_ready` is low.
- R6: In peripheral-to-memory mode, bytes accepted on the receive stream are written to consecutive memory addresses starting at base.
- R7: The bytes-remaining register loads the active slot's count when that slot starts, and it drops by one on each granted memory beat.
- R8: When the active buffer ends with the other slot armed, the channel makes that slot active and the state is on. Interrupt status bit 1 (next-free) is set while the state is on.
- R9: When the active buffer ends with nothing else armed, the state goes to stall and interrupt status bit 0 (stall) is set. `irq` is the OR of each status bit ANDed with its enable.
- R10: `per_err` sets interrupt status bit 3 while the channel is not idle, and the current buffer still completes. Writing 1 to bit 3 clears it.
- R11: Clearing the enable lets the active buffer finish, discards the other armed slot, passes through stall to idle and resets the active slot to 0.
- R12: If the other slot is armed in the very cycle the active buffer ends, the channel goes straight to that slot in state on, without stalling.
- R13: A buffer with a count of zero completes at once, with no memory beat and no stream byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for `reg_addr` |
| irq | output | 1 | Combined interrupt line |
| port_sel | output | PSEL_W | Peripheral port select value |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | Beat is a write |
| mem_addr | output | AW | Beat byte address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid with grant |
| mem_gnt | input | 1 | Grant; completes the beat |
| tx_data | output | DW | Byte to peripheral |
| tx_valid | output | 1 | Byte to peripheral valid |
| tx_ready | input | 1 | Peripheral accepts byte |
| rx_data | input | DW | Byte from peripheral |
| rx_valid | input | 1 | Byte from peripheral valid |
| rx_ready | output | 1 | Channel accepts byte |
| per_err | input | 1 | Peripheral error pulse |

## Verification
Two events can land on the same clock edge: the end of the active buffer, and a base write that arms the other slot. The bench sets up that collision deliberately. It holds `tx_ready` low on a one-byte buffer until the byte sits on the stream, then releases it, and issues the base write on the edge where the completion is seen. The outcome is judged from the status register, which must show state on with the active slot pointer flipped and no detour through stall, and from the total count of bytes delivered across both buffers.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_STALL = 2'd1,
    ST_ON    = 2'd2,
    ST_NEXT  = 2'd3
  } chan_st_e;

  localparam int REG_W = 32;

  localparam logic [7:0] OFS_CTRL  = 8'h00;
  localparam logic [7:0] OFS_INT   = 8'h04;
  localparam logic [7:0] OFS_PSEL  = 8'h08;
  localparam logic [7:0] OFS_STAT  = 8'h0C;
  localparam logic [7:0] OFS_REM   = 8'h14;
  localparam logic [7:0] OFS_CNT0  = 8'h20;
  localparam logic [7:0] OFS_BASE0 = 8'h24;
  localparam logic [7:0] OFS_CNT1  = 8'h30;
  localparam logic [7:0] OFS_BASE1 = 8'h34;
  localparam logic [7:0] SLOT_STRIDE = 8'h10;

  localparam int CB_STALL_IE = 0;
  localparam int CB_NFB_IE   = 1;
  localparam int CB_DIR      = 2;
  localparam int CB_ERR_IE   = 3;
  localparam int CB_EN       = 4;
  localparam int CTRL_W      = 5;
endpackage

// File: rtl/dma_desc_slots.sv
module dma_desc_slots
  import dma_chan_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   we,
  input  logic [7:0]             addr,
  input  logic [REG_W-1:0]       wdata,
  output logic [1:0][CW-1:0]     cnt_q,
  output logic [1:0][AW-1:0]     base_q,
  output logic [1:0]             base_wr
);
  for (genvar g = 0; g < 2; g++) begin : g_slot
    localparam logic [7:0] CNT_OFS  = 8'(OFS_CNT0  + SLOT_STRIDE * g);
    localparam logic [7:0] BASE_OFS = 8'(OFS_BASE0 + SLOT_STRIDE * g);

    assign base_wr[g] = we && (addr == BASE_OFS);

    always_ff @(posedge clk) begin
      if (rst) begin
        cnt_q[g]  <= '0;
        base_q[g] <= '0;
      end else begin
        if (we && (addr == CNT_OFS)) cnt_q[g] <= wdata[CW-1:0];
        if (base_wr[g])              base_q[g] <= wdata[AW-1:0];
      end
    end
  end
endmodule

// File: rtl/dma_byte_mover.sv
module dma_byte_mover #(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          dir,
  input  logic          load,
  input  logic [CW-1:0] load_cnt,
  input  logic [AW-1:0] load_base,
  output logic [CW-1:0] rem,
  output logic          done,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_gnt,
  output logic [DW-1:0] tx_data,
  output logic          tx_valid,
  input  logic          tx_ready,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_valid,
  output logic          rx_ready
);
  logic [AW-1:0] ptr;
  logic [DW-1:0] hold;
  logic          hold_v;
  logic          req;

  assign mem_req   = req;
  assign mem_we    = dir;
  assign mem_addr  = ptr;
  assign mem_wdata = hold;
  assign tx_data   = hold;
  assign tx_valid  = hold_v && !dir;
  assign rx_ready  = run && dir && !hold_v && !req && (rem != '0);
  assign done      = run && (rem == '0) && !hold_v && !req;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr    <= '0;
      rem    <= '0;
      hold   <= '0;
      hold_v <= 1'b0;
      req    <= 1'b0;
    end else if (load) begin
      ptr    <= load_base;
      rem    <= load_cnt;
      hold_v <= 1'b0;
      req    <= 1'b0;
    end else if (run) begin
      if (!dir && hold_v) begin
        if (tx_ready) hold_v <= 1'b0;
      end else if (req) begin
        if (mem_gnt) begin
          req <= 1'b0;
          ptr <= ptr + 1'b1;
          rem <= rem - 1'b1;
          if (!dir) begin
            hold   <= mem_rdata;
            hold_v <= 1'b1;
          end else begin
            hold_v <= 1'b0;
          end
        end
      end else if (rem != '0) begin
        if (!dir) begin
          req <= 1'b1;
        end else if (rx_valid) begin
          hold   <= rx_data;
          hold_v <= 1'b1;
          req    <= 1'b1;
        end
      end
    end
  end

  AST_REM_LOAD: assert property (@(posedge clk) disable iff (rst)
    load |=> (rem == $past(load_cnt)));                                   // R7
  AST_REM_STEP: assert property (@(posedge clk) disable iff (rst)
    (run && !load && req && mem_gnt) |=> (rem == $past(rem) - CW'(1)));    // R7
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (run && !load && req && mem_gnt) |=> (mem_addr == $past(mem_addr) + AW'(1))); // R6
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready && !load) |=> (tx_valid && $stable(tx_data)));  // R5
endmodule

// File: rtl/dma_chan.sv
module dma_chan
  import dma_chan_pkg::*;
#(
  parameter int AW     = 32,
  parameter int CW     = 16,
  parameter int DW     = 8,
  parameter int PSEL_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [7:0]        reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              irq,
  output logic [PSEL_W-1:0] port_sel,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic [DW-1:0]     mem_rdata,
  input  logic              mem_gnt,
  output logic [DW-1:0]     tx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  input  logic [DW-1:0]     rx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic              per_err
);
  chan_st_e             state;
  logic                 act;
  logic [1:0]           pend;
  logic [CTRL_W-1:0]    ctrl_q;
  logic [PSEL_W-1:0]    psel_q;
  logic                 err_q;
  logic [1:0][CW-1:0]   cnt_q;
  logic [1:0][AW-1:0]   base_q;
  logic [1:0]           base_wr;
  logic [1:0]           arm_w;
  logic                 en, other, run, load, load_slot, mv_done;
  logic [CW-1:0]        mv_rem;
  logic [AW-1:0]        load_base;
  logic                 st_stall, st_nfb;
  logic [REG_W-1:0]     rd_mux;

  dma_desc_slots #(.AW(AW), .CW(CW)) u_slots (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .cnt_q(cnt_q), .base_q(base_q), .base_wr(base_wr)
  );

  assign en        = ctrl_q[CB_EN];
  assign other     = ~act;
  assign arm_w     = base_wr & ~pend & {2{en && (state != ST_IDLE)}};
  assign run       = (state == ST_ON) || (state == ST_NEXT);
  assign load      = ((state == ST_STALL) && en && (|arm_w)) ||
                     ((state == ST_ON)    && mv_done && arm_w[other]) ||
                     ((state == ST_NEXT)  && mv_done && en);
  assign load_slot = (state == ST_STALL) ? arm_w[1] : other;
  assign load_base = base_wr[load_slot] ? reg_wdata[AW-1:0] : base_q[load_slot];

  dma_byte_mover #(.AW(AW), .CW(CW), .DW(DW)) u_mover (
    .clk(clk), .rst(rst), .run(run), .dir(ctrl_q[CB_DIR]),
    .load(load), .load_cnt(cnt_q[load_slot]), .load_base(load_base),
    .rem(mv_rem), .done(mv_done),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_gnt(mem_gnt),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      act   <= 1'b0;
      pend  <= '0;
    end else begin
      case (state)
        ST_IDLE:  if (en) state <= ST_STALL;
        ST_STALL: begin
          if (!en) begin
            state <= ST_IDLE;
            act   <= 1'b0;
            pend  <= '0;
          end else if (|arm_w) begin
            state <= ST_ON;
            act   <= arm_w[1];
            pend  <= arm_w;
          end
        end
        ST_ON: begin
          if (mv_done) begin
            if (arm_w[other]) begin
              pend[act]   <= 1'b0;
              pend[other] <= 1'b1;
              act         <= other;
            end else begin
              pend  <= '0;
              state <= ST_STALL;
            end
          end else if (arm_w[other]) begin
            pend[other] <= 1'b1;
            state       <= ST_NEXT;
          end
        end
        ST_NEXT: begin
          if (mv_done) begin
            if (en) begin
              pend[act] <= 1'b0;
              act       <= other;
              state     <= ST_ON;
            end else begin
              pend  <= '0;
              state <= ST_STALL;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign st_stall = (state == ST_STALL);
  assign st_nfb   = (state == ST_ON);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      psel_q <= '0;
      err_q  <= 1'b0;
      irq    <= 1'b0;
    end else begin
      if (reg_we && (reg_addr == OFS_CTRL)) ctrl_q <= reg_wdata[CTRL_W-1:0];
      if (reg_we && (reg_addr == OFS_PSEL)) psel_q <= reg_wdata[PSEL_W-1:0];
      if (per_err && (state != ST_IDLE))
        err_q <= 1'b1;
      else if (reg_we && (reg_addr == OFS_INT) && reg_wdata[3])
        err_q <= 1'b0;
      irq <= (st_stall && ctrl_q[CB_STALL_IE]) || (st_nfb && ctrl_q[CB_NFB_IE]) ||
             (err_q && ctrl_q[CB_ERR_IE]);
    end
  end

  assign port_sel = psel_q;

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      OFS_CTRL:  rd_mux[CTRL_W-1:0] = ctrl_q;
      OFS_INT:   rd_mux[3:0] = {err_q, 1'b0, st_nfb, st_stall};
      OFS_PSEL:  rd_mux[PSEL_W-1:0] = psel_q;
      OFS_STAT:  begin rd_mux[5:4] = state; rd_mux[0] = act; end
      OFS_REM:   rd_mux[CW-1:0] = mv_rem;
      OFS_CNT0:  rd_mux[CW-1:0] = cnt_q[0];
      OFS_BASE0: rd_mux[AW-1:0] = base_q[0];
      OFS_CNT1:  rd_mux[CW-1:0] = cnt_q[1];
      OFS_BASE1: rd_mux[AW-1:0] = base_q[1];
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_mux;
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> !mem_req);                                     // R11
  AST_DRAIN_IDLE: assert property (@(posedge clk) disable iff (rst)
    (state == ST_STALL && !en) |=> (state == ST_IDLE));                   // R11
  AST_DONE_STALL: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ON && mv_done && !load) |=> (state == ST_STALL));        // R9
  AST_HANDOVER: assert property (@(posedge clk) disable iff (rst)
    (state == ST_NEXT && mv_done && en) |=> (state == ST_ON && act != $past(act))); // R8
  AST_SAME_EDGE_ARM: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ON && mv_done && load) |=> (state == ST_ON));            // R12
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (per_err && state != ST_IDLE) |=> err_q);                             // R10
endmodule

// File: tb/dma_chan_tb.sv
module dma_chan_tb;
  import dma_chan_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32, CW = 16, DW = 8, PSEL_W = 4;

  localparam logic [31:0] VBASE [0:3] = '{32'h0000_0100, 32'h0000_01F0, 32'h0000_0033, 32'h0000_0080};
  localparam logic [15:0] VCNT  [0:3] = '{16'd4, 16'd1, 16'd6, 16'd3};

  logic clk = 1'b0, rst = 1'b1;
  logic reg_we = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic irq;
  logic [PSEL_W-1:0] port_sel;
  logic mem_req, mem_we, mem_gnt;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata, tx_data;
  logic tx_valid, tx_ready, rx_ready;
  logic [DW-1:0] rx_data = '0;
  logic rx_valid = 1'b0, per_err = 1'b0, tx_rdy_en = 1'b1, gnt_ph;
  logic [7:0] txlog [0:255];
  logic [7:0] wmem  [0:255];
  int txn = 0;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chan #(.AW(AW), .CW(CW), .DW(DW), .PSEL_W(PSEL_W)) u_dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq), .port_sel(port_sel),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_gnt(mem_gnt),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready), .per_err(per_err)
  );

  // memory model: grant every other cycle, read data is a function of address
  always @(posedge clk) gnt_ph <= rst ? 1'b0 : ~gnt_ph;
  assign mem_gnt   = mem_req && gnt_ph;
  assign mem_rdata = mem_addr[7:0] ^ 8'hA5;
  assign tx_ready  = tx_rdy_en;

  always @(posedge clk) begin
    if (!rst && tx_valid && tx_ready) begin
      txlog[txn[7:0]] <= tx_data;
      txn <= txn + 1;
    end
    if (mem_req && mem_gnt && mem_we) wmem[mem_addr[7:0]] <= mem_wdata;
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk); reg_addr = a;
    @(negedge clk); v = reg_rdata;
  endtask

  task automatic wait_state(input logic [1:0] s);
    logic [31:0] v;
    for (int k = 0; k < 3000; k++) begin
      rd(OFS_STAT, v);
      if (v[5:4] == s) return;
    end
  endtask

  task automatic chk_bytes(input string tag, input int start, input logic [31:0] base, input int n);
    for (int j = 0; j < n; j++) begin
      logic [31:0] a = base + 32'(j);
      chk(tag, {24'b0, txlog[(start + j) & 255]}, {24'b0, a[7:0] ^ 8'hA5});
    end
  endtask

  task automatic send_rx(input logic [7:0] d);
    @(negedge clk); rx_data = d; rx_valid = 1'b1;
    while (!rx_ready) @(negedge clk);
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int t0;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(OFS_CTRL, v); chk("R1 ctrl", v, 0);
    rd(OFS_STAT, v); chk("R1 status", v, 0);
    rd(OFS_REM, v);  chk("R1 remaining", v, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 mem_req", {31'b0, mem_req}, 0);

    // R3 base write while disabled is ignored; enable goes to stall
    wr(OFS_CNT0, 2); wr(OFS_BASE0, 32'h10);
    rd(OFS_STAT, v); chk("R3 disabled arm ignored", v, 0);
    wr(OFS_CTRL, 32'h10);
    repeat (3) @(negedge clk);
    rd(OFS_STAT, v); chk("R3 enable to stall", v, 32'h10);
    chk("R3 no request", {31'b0, mem_req}, 0);

    // R2 register map
    rd(OFS_CTRL, v); chk("R2 ctrl readback", v, 32'h10);
    wr(OFS_PSEL, 5);
    rd(OFS_PSEL, v); chk("R2 port select reg", v, 5);
    chk("R2 port_sel pin", {28'b0, port_sel}, 5);
    wr(OFS_CNT1, 32'h1234);
    rd(OFS_CNT1, v); chk("R2 slot1 count", v, 32'h1234);

    // R4 arming and state encoding, R7 remaining
    tx_rdy_en = 1'b0;
    t0 = txn;
    wr(OFS_CNT0, 2); wr(OFS_BASE0, 32'h200);
    rd(OFS_STAT, v); chk("R4 stall to on", v, 32'h20);
    wr(OFS_CNT1, 20); wr(OFS_BASE1, 32'h300);
    rd(OFS_STAT, v); chk("R4 on to next", v, 32'h30);
    repeat (4) @(negedge clk);
    rd(OFS_REM, v); chk("R7 remaining after one beat", v, 1);
    chk("R5 byte held", {24'b0, tx_data}, 32'hA5);
    chk("R5 valid held", {31'b0, tx_valid}, 1);

    // R8 handover and next-free status
    wr(OFS_CTRL, 32'h13);
    rd(OFS_INT, v); chk("R8 no flags in next", v, 0);
    tx_rdy_en = 1'b1;
    wait_state(2'd2);
    rd(OFS_STAT, v); chk("R8 slot1 active", v, 32'h21);
    rd(OFS_INT, v);  chk("R8 next-free bit", v, 2);
    chk("R8 irq next-free", {31'b0, irq}, 1);
    wait_state(2'd1);
    rd(OFS_INT, v);  chk("R9 stall bit", v, 1);
    chk("R9 irq stall", {31'b0, irq}, 1);
    chk("R5 byte count", txn - t0, 22);
    chk_bytes("R5 order buf0", t0, 32'h200, 2);
    chk_bytes("R5 order buf1", t0 + 2, 32'h300, 20);
    wr(OFS_CTRL, 32'h10);
    repeat (2) @(negedge clk);
    chk("R9 irq masked", {31'b0, irq}, 0);

    // vector table of single buffers, alternating slots
    for (int i = 0; i < 4; i++) begin
      t0 = txn;
      wr((i % 2 == 0) ? OFS_CNT0 : OFS_CNT1, {16'b0, VCNT[i]});
      wr((i % 2 == 0) ? OFS_BASE0 : OFS_BASE1, VBASE[i]);
      wait_state(2'd1);
      chk("R5 vector count", txn - t0, int'(VCNT[i]));
      chk_bytes("R5 vector data", t0, VBASE[i], int'(VCNT[i]));
      rd(OFS_REM, v); chk("R7 vector remaining zero", v, 0);
    end

    // R12 arm the other slot in the cycle the active buffer completes
    tx_rdy_en = 1'b0;
    t0 = txn;
    wr(OFS_CNT0, 1); wr(OFS_CNT1, 3);
    wr(OFS_BASE0, 32'h50);
    while (!tx_valid) @(negedge clk);
    tx_rdy_en = 1'b1;
    @(negedge clk);
    reg_addr = OFS_BASE1; reg_wdata = 32'h60; reg_we = 1'b1;
    @(negedge clk); reg_we = 1'b0;
    rd(OFS_STAT, v); chk("R12 straight to on, slot1", v, 32'h21);
    wait_state(2'd1);
    chk("R12 byte count", txn - t0, 4);
    chk_bytes("R12 data", t0, 32'h50, 1);
    chk_bytes("R12 data second", t0 + 1, 32'h60, 3);

    // R13 zero count
    t0 = txn;
    wr(OFS_CNT0, 0); wr(OFS_BASE0, 32'h70);
    repeat (4) @(negedge clk);
    rd(OFS_STAT, v); chk("R13 zero count completes", v, 32'h10);
    chk("R13 no bytes", txn - t0, 0);

    // R10 error flag
    tx_rdy_en = 1'b0;
    t0 = txn;
    wr(OFS_CNT1, 3); wr(OFS_BASE1, 32'h90);
    @(negedge clk); per_err = 1'b1;
    @(negedge clk); per_err = 1'b0;
    rd(OFS_INT, v); chk("R10 error set while on", v, 32'hA);
    tx_rdy_en = 1'b1;
    wait_state(2'd1);
    chk("R10 transfer completes", txn - t0, 3);
    rd(OFS_INT, v); chk("R10 error sticky", v, 32'h9);
    wr(OFS_CTRL, 32'h18);
    repeat (2) @(negedge clk);
    chk("R10 irq on error", {31'b0, irq}, 1);
    wr(OFS_INT, 32'h8);
    rd(OFS_INT, v); chk("R10 write one clears", v, 1);
    repeat (2) @(negedge clk);
    chk("R10 irq cleared", {31'b0, irq}, 0);

    // R6 peripheral to memory, R7 remaining
    wr(OFS_CTRL, 32'h14);
    wr(OFS_CNT0, 3); wr(OFS_BASE0, 32'h40);
    rd(OFS_REM, v); chk("R7 rx remaining loaded", v, 3);
    send_rx(8'h11);
    repeat (4) @(negedge clk);
    rd(OFS_REM, v); chk("R7 rx remaining step", v, 2);
    send_rx(8'h22);
    send_rx(8'h33);
    wait_state(2'd1);
    chk("R6 mem byte 0", {24'b0, wmem[8'h40]}, 32'h11);
    chk("R6 mem byte 1", {24'b0, wmem[8'h41]}, 32'h22);
    chk("R6 mem byte 2", {24'b0, wmem[8'h42]}, 32'h33);

    // R11 drain on disable
    wr(OFS_CTRL, 32'h10);
    tx_rdy_en = 1'b0;
    t0 = txn;
    wr(OFS_CNT0, 3); wr(OFS_BASE0, 32'hA0);
    wr(OFS_CNT1, 3); wr(OFS_BASE1, 32'hB0);
    wr(OFS_CTRL, 32'h00);
    rd(OFS_STAT, v); chk("R11 still next after disable", {30'b0, v[5:4]}, 3);
    tx_rdy_en = 1'b1;
    wait_state(2'd0);
    chk("R11 only active buffer drained", txn - t0, 3);
    chk_bytes("R11 drained data", t0, 32'hA0, 3);
    chk("R11 idle no request", {31'b0, mem_req}, 0);
    wr(OFS_CTRL, 32'h10);
    repeat (3) @(negedge clk);
    rd(OFS_STAT, v); chk("R11 pointer reset", v, 32'h10);
    tx_rdy_en = 1'b0;
    wr(OFS_CNT1, 1); wr(OFS_BASE1, 32'hC0);
    rd(OFS_STAT, v); chk("R11 discarded slot re-armable", v, 32'h21);
    tx_rdy_en = 1'b1;
    wait_state(2'd1);

    finish_run();
  end
endmodule